// File: doc/BRIEF.md
# Iterative Multi-Coordinate CORDIC Engine

This block is a sequential shift-and-add rotator. It works on three signed fixed-point registers, x, y and z, and performs one micro-rotation on each clock. At the start of each job the caller chooses two things:

- **The coordinate system:** circular, linear or hyperbolic.
- **The steering rule:** rotation, which drives z toward zero, or vectoring, which drives y toward zero.

With these choices the single datapath can produce several results:

- sine and cosine products;
- vector magnitude and angle;
- multiply-accumulate and division;
- hyperbolic functions and inverse hyperbolic tangent.

The block holds an internal table with one elementary angle per step for each coordinate system. Gain compensation, argument range reduction and any floating-point packing are left to the logic around the block.

A job is handed over on a valid/ready request port. `in_ready` is high only while the engine is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While the engine iterates, `in_ready` stays low, and a request offered then is not taken: the source keeps it, or drops it, at its own choice. Results have no back-pressure. `done` rises when the last step has been written. It stays high, and the outputs stay frozen, until the next request is taken.

All data ports use a two's-complement format with two integer bits and FRAC fraction bits. With the default settings this is 32 bits with 30 fraction bits, so the value v is encoded as round-down(v·2^30). The caller keeps operands small enough that every intermediate value stays inside ±2.

Top module: `cordic_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0, and `out_x`, `out_y` and `out_z` are all zero.
- R2: A request is taken only on an edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` is 0 and `done` is 0 until the job ends. A request offered while `in_ready` is 0 changes neither the running job nor its results.
- R3: Coordinate codes 0 (circular), 1 (linear) and 3 (linear) run steps k = 0 to ITER−1. With ITER = 32, `done` rises 32 cycles after the accepting edge. Code 2 (hyperbolic) starts at k = 1 and repeats each step k in the series 4, 13, 40, … (k' = 3k+1) that lies below ITER once. With ITER = 32 that is 33 steps, so `done` rises 33 cycles after the accepting edge. `in_ready` returns to 1 in the same cycle as `done`.
- R4: While `done` is 1 and no request is taken, `done` stays 1 and the three outputs hold their values. Taking the next request clears `done`.
- R5: Circular rotation (`in_vect` = 0) gives x → K(x·cos z − y·sin z), y → K(y·cos z + x·sin z) and z → 0. Here K = ∏ sqrt(1+2^(−2k)) over the executed steps. The direction of each step is +1 when z ≥ 0 and −1 otherwise.
- R6: Circular vectoring (`in_vect` = 1, x > 0) gives x → K·sqrt(x²+y²), y → 0 and z → z + atan(y/x). The direction of each step is +1 when y < 0 and −1 otherwise.
- R7: Linear rotation keeps x unchanged and gives y → y + x·z and z → 0.
- R8: Linear vectoring (x > 0) keeps x unchanged and gives y → 0 and z → z + y/x.
- R9: Hyperbolic rotation gives x → Kh(x·cosh z + y·sinh z), y → Kh(y·cosh z + x·sinh z) and z → 0. Here Kh = ∏ sqrt(1−2^(−2k)) over the executed steps, repeats included.
- R10: Hyperbolic vectoring (x > |y|) gives x → Kh·sqrt(x²−y²), y → 0 and z → z + atanh(y/x).
- R11: Coordinate code 3 produces exactly the results of code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A job request is offered |
| in_ready | output | 1 | Engine is idle and will take a request |
| in_coord | input | 2 | 0 circular, 1 linear, 2 hyperbolic, 3 linear |
| in_vect | input | 1 | 0 rotation (steer z to 0), 1 vectoring (steer y to 0) |
| in_x | input | DW | Initial x, signed fixed point |
| in_y | input | DW | Initial y, signed fixed point |
| in_z | input | DW | Initial z, signed fixed point |
| done | output | 1 | Job finished; held until the next request is taken |
| out_x | output | DW | Final x |
| out_y | output | DW | Final y |
| out_z | output | DW | Final z |

## Verification
Each of the six combinations of coordinate system and steering rule is given its own operands, including both signs of z and of y. A wrong step direction, a swapped sign in the x update, or a table filled for the wrong system therefore moves at least one output well beyond the tolerance. The run length distinguishes the 32-step systems from the hyperbolic sequence with repeats: a missing or extra repeat changes both the cycle count and the hyperbolic gain. Code 3 is run with the same kind of operands as code 1 to show that the two behave alike. A second request offered mid-job must leave the first job's results untouched. A wait after completion shows that the outputs and `done` are held.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic [1:0] {
    CO_CIRC = 2'd0,
    CO_LIN  = 2'd1,
    CO_HYP  = 2'd2,
    CO_LIN2 = 2'd3
  } coord_e;

  // first repeated hyperbolic step; later ones follow k' = 3k + 1
  localparam int HYP_FIRST_REPEAT = 4;

endpackage

// File: rtl/cordic_angle_rom.sv
module cordic_angle_rom #(
  parameter int DW   = 32,
  parameter int FRAC = 30,
  parameter int ITER = 32,
  parameter int KW   = $clog2(ITER + 1)
) (
  input  logic [1:0]           coord,
  input  logic [KW-1:0]        k,
  output logic signed [DW-1:0] angle
);
  import cordic_pkg::*;

  localparam int  NT    = 2 ** KW;
  localparam real SCALE = 2.0 ** FRAC;

  logic signed [DW-1:0] tab_circ [NT];
  logic signed [DW-1:0] tab_lin  [NT];
  logic signed [DW-1:0] tab_hyp  [NT];

  for (genvar i = 0; i < NT; i++) begin : g_tab
    if (i < ITER) begin : g_live
      localparam real    ARG_H = 2.0 ** (-((i == 0) ? 1 : i));
      localparam longint VC    = longint'($atan(2.0 ** (-i)) * SCALE);
      localparam longint VL    = longint'((2.0 ** (-i)) * SCALE);
      localparam longint VH    = (i == 0) ? 64'sd0 : longint'($atanh(ARG_H) * SCALE);
      assign tab_circ[i] = DW'(VC);
      assign tab_lin[i]  = DW'(VL);
      assign tab_hyp[i]  = DW'(VH);
    end else begin : g_pad
      assign tab_circ[i] = '0;
      assign tab_lin[i]  = '0;
      assign tab_hyp[i]  = '0;
    end
  end

  always_comb begin
    unique case (coord_e'(coord))
      CO_CIRC: angle = tab_circ[k];
      CO_HYP:  angle = tab_hyp[k];
      default: angle = tab_lin[k];
    endcase
  end

endmodule

// File: rtl/cordic_step.sv
module cordic_step #(
  parameter int DW = 32,
  parameter int KW = 6
) (
  input  logic [1:0]           coord,
  input  logic                 vect,
  input  logic [KW-1:0]        k,
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] y,
  input  logic signed [DW-1:0] z,
  input  logic signed [DW-1:0] angle,
  output logic signed [DW-1:0] nx,
  output logic signed [DW-1:0] ny,
  output logic signed [DW-1:0] nz
);
  import cordic_pkg::*;

  logic                 pos;      // step direction is +1
  logic signed [DW-1:0] xs, ys;

  always_comb begin
    pos = vect ? y[DW-1] : ~z[DW-1];
    xs  = x >>> k;
    ys  = y >>> k;
    ny  = pos ? (y + xs) : (y - xs);
    nz  = pos ? (z - angle) : (z + angle);
    unique case (coord_e'(coord))
      CO_CIRC: nx = pos ? (x - ys) : (x + ys);
      CO_HYP:  nx = pos ? (x + ys) : (x - ys);
      default: nx = x;
    endcase
  end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int ITER = 32,
  parameter int KW   = $clog2(ITER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          accept_hyp,
  input  logic          run_hyp,
  output logic          busy,
  output logic          done,
  output logic [KW-1:0] k
);
  import cordic_pkg::*;

  localparam int RW = KW + 2;

  logic [RW-1:0] rep_at;
  logic          rep_taken;
  logic          repeat_now;
  logic          last_step;

  assign repeat_now = run_hyp && !rep_taken && (RW'(k) == rep_at);
  assign last_step  = (k == KW'(ITER - 1)) && !repeat_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      k         <= '0;
      rep_at    <= RW'(HYP_FIRST_REPEAT);
      rep_taken <= 1'b0;
    end else if (accept) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      k         <= accept_hyp ? KW'(1) : '0;
      rep_at    <= RW'(HYP_FIRST_REPEAT);
      rep_taken <= 1'b0;
    end else if (busy) begin
      if (repeat_now) begin
        rep_taken <= 1'b1;
        rep_at    <= rep_at + (rep_at << 1) + RW'(1);
      end else begin
        rep_taken <= 1'b0;
        k         <= k + KW'(1);
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine #(
  parameter int DW   = 32,
  parameter int FRAC = 30,
  parameter int ITER = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_coord,
  input  logic          in_vect,
  input  logic [DW-1:0] in_x,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_z,
  output logic          done,
  output logic [DW-1:0] out_x,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_z
);
  import cordic_pkg::*;

  localparam int KW = $clog2(ITER + 1);

  logic                 accept;
  logic                 busy;
  logic [KW-1:0]        k;
  logic [1:0]           coord_q;
  logic                 vect_q;
  logic signed [DW-1:0] x_q, y_q, z_q;
  logic signed [DW-1:0] x_n, y_n, z_n;
  logic signed [DW-1:0] angle;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  cordic_ctrl #(.ITER(ITER), .KW(KW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .accept_hyp (in_coord == CO_HYP),
    .run_hyp    (coord_q == CO_HYP),
    .busy       (busy),
    .done       (done),
    .k          (k)
  );

  cordic_angle_rom #(.DW(DW), .FRAC(FRAC), .ITER(ITER), .KW(KW)) u_rom (
    .coord (coord_q),
    .k     (k),
    .angle (angle)
  );

  cordic_step #(.DW(DW), .KW(KW)) u_step (
    .coord (coord_q),
    .vect  (vect_q),
    .k     (k),
    .x     (x_q),
    .y     (y_q),
    .z     (z_q),
    .angle (angle),
    .nx    (x_n),
    .ny    (y_n),
    .nz    (z_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coord_q <= CO_CIRC;
      vect_q  <= 1'b0;
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
    end else if (accept) begin
      coord_q <= in_coord;
      vect_q  <= in_vect;
      x_q     <= in_x;
      y_q     <= in_y;
      z_q     <= in_z;
    end else if (busy) begin
      x_q <= x_n;
      y_q <= y_n;
      z_q <= z_n;
    end
  end

  assign out_x = x_q;
  assign out_y = y_q;
  assign out_z = z_q;

endmodule

// File: rtl/cordic_engine_chk.sv
module cordic_engine_chk #(
  parameter int DW   = 32,
  parameter int ITER = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_coord,
  input logic          done,
  input logic [DW-1:0] out_x,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_z
);

  function automatic int hyp_steps(int it);
    int n = it - 1;
    int r = 4;
    while (r < it) begin
      n++;
      r = 3 * r + 1;
    end
    return n;
  endfunction

  localparam int LEN_PLAIN = ITER;
  localparam int LEN_HYP   = hyp_steps(ITER);

  int run_len;
  int exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 0;
      exp_len <= LEN_PLAIN;
    end else if (in_valid && in_ready) begin
      run_len <= 0;
      exp_len <= (in_coord == 2'd2) ? LEN_HYP : LEN_PLAIN;
    end else if (!in_ready) begin
      run_len <= run_len + 1;
    end
  end

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !done));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !in_valid) |=> (done && $stable(out_x) && $stable(out_y) && $stable(out_z)));

  p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (run_len == exp_len));

  p_ready_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $rose(done));

endmodule

bind cordic_engine cordic_engine_chk #(.DW(DW), .ITER(ITER)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_coord (in_coord),
  .done     (done),
  .out_x    (out_x),
  .out_y    (out_y),
  .out_z    (out_z)
);

// File: tb/test_cordic_engine.sv
module test_cordic_engine;

  localparam int  DW   = 32;
  localparam int  FRAC = 30;
  localparam int  ITER = 32;
  localparam real SC   = 2.0 ** FRAC;
  localparam real TOL  = 4.0e-6;

  typedef struct {
    real   ex, ey, ez;
    int    lat;
    int    acc_cyc;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_coord = '0;
  logic          in_vect = 1'b0;
  logic [DW-1:0] in_x = '0, in_y = '0, in_z = '0;
  logic          done;
  logic [DW-1:0] out_x, out_y, out_z;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   finished = 1'b0;
  bit   done_prev = 1'b0;
  exp_t sb[$];
  real  kc, kh;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cordic_engine #(.DW(DW), .FRAC(FRAC), .ITER(ITER)) i_cordic_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coord(in_coord), .in_vect(in_vect), .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .done(done), .out_x(out_x), .out_y(out_y), .out_z(out_z)
  );

  function automatic logic [DW-1:0] fx(real v);
    return DW'(longint'($floor(v * SC)));
  endfunction

  function automatic real fr(logic [DW-1:0] v);
    return $itor($signed(v)) / SC;
  endfunction

  task automatic chk_real(string tag, string what, real got, real exp);
    checks++;
    if ((got - exp > TOL) || (exp - got > TOL)) begin
      errors++;
      $display("FAIL %s %s: got %f expected %f", tag, what, got, exp);
    end
  endtask

  task automatic chk_int(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // monitor: pop expectation when done rises
  always @(negedge clk) begin
    if (rst_n && done && !done_prev) begin
      if (sb.size() == 0) begin
        chk_int("R2", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk_real(e.tag, "x", fr(out_x), e.ex);
        chk_real(e.tag, "y", fr(out_y), e.ey);
        chk_real(e.tag, "z", fr(out_z), e.ez);
        chk_int("R3", {e.tag, " latency"}, cyc - e.acc_cyc, e.lat);
      end
    end
    done_prev = done;
  end

  // driver
  task automatic run_job(logic [1:0] co, logic vec, real x, real y, real z,
                         real ex, real ey, real ez, string tag, bit poke);
    exp_t e;
    logic [DW-1:0] hx, hy, hz;
    @(negedge clk);
    chk_int("R2", "in_ready before request", int'(in_ready), 1);
    in_coord = co; in_vect = vec;
    in_x = fx(x); in_y = fx(y); in_z = fx(z);
    in_valid = 1'b1;
    e.ex = ex; e.ey = ey; e.ez = ez; e.tag = tag;
    e.lat = (co == 2'd2) ? ITER + 1 : ITER;
    @(negedge clk);
    in_valid = 1'b0;
    e.acc_cyc = cyc;
    sb.push_back(e);
    chk_int("R4", "done cleared after accept", int'(done), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk_int("R2", "in_ready low while busy", int'(in_ready), 0);
      in_coord = 2'd1; in_vect = 1'b0;
      in_x = fx(1.5); in_y = fx(-1.5); in_z = fx(1.0);
      in_valid = 1'b1;
      repeat (2) @(negedge clk);
      in_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    hx = out_x; hy = out_y; hz = out_z;
    repeat (4) @(negedge clk);
    chk_int("R4", "done held", int'(done), 1);
    chk_int("R4", "outputs held", int'({out_x, out_y, out_z} == {hx, hy, hz}), 1);
  endtask

  initial begin
    kc = 1.0;
    for (int i = 0; i < ITER; i++) kc = kc * $sqrt(1.0 + 2.0 ** (-2 * i));
    kh = 1.0;
    begin
      int r = 4;
      for (int i = 1; i < ITER; i++) begin
        kh = kh * $sqrt(1.0 - 2.0 ** (-2 * i));
        if (i == r) begin
          kh = kh * $sqrt(1.0 - 2.0 ** (-2 * i));
          r = 3 * r + 1;
        end
      end
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_int("R1", "in_ready after reset", int'(in_ready), 1);
    chk_int("R1", "done after reset", int'(done), 0);
    chk_int("R1", "outputs after reset", int'({out_x, out_y, out_z} == '0), 1);

    // R5 circular rotation, first job poked while busy (R2)
    run_job(2'd0, 1'b0, 0.6, 0.0, 0.5,
            kc * 0.6 * $cos(0.5), kc * 0.6 * $sin(0.5), 0.0, "R5", 1'b1);
    run_job(2'd0, 1'b0, 0.3, 0.4, -1.0,
            kc * (0.3 * $cos(-1.0) - 0.4 * $sin(-1.0)),
            kc * (0.4 * $cos(-1.0) + 0.3 * $sin(-1.0)), 0.0, "R5", 1'b0);
    // R6 circular vectoring
    run_job(2'd0, 1'b1, 0.5, 0.4, 0.0,
            kc * $sqrt(0.41), 0.0, $atan(0.8), "R6", 1'b0);
    run_job(2'd0, 1'b1, 0.6, -0.3, 0.1,
            kc * $sqrt(0.45), 0.0, 0.1 + $atan(-0.5), "R6", 1'b0);
    // R7 linear rotation
    run_job(2'd1, 1'b0, 0.5, 0.1, 0.75, 0.5, 0.475, 0.0, "R7", 1'b1);
    // R8 linear vectoring
    run_job(2'd1, 1'b1, 0.8, 0.3, 0.0, 0.8, 0.0, 0.375, "R8", 1'b0);
    // R11 code 3 acts as linear
    run_job(2'd3, 1'b0, 0.5, -0.2, 0.5, 0.5, 0.05, 0.0, "R11", 1'b0);
    run_job(2'd3, 1'b1, 0.8, -0.2, 0.1, 0.8, 0.0, -0.15, "R11", 1'b0);
    // R9 hyperbolic rotation
    run_job(2'd2, 1'b0, 1.0, 0.0, 0.5,
            kh * $cosh(0.5), kh * $sinh(0.5), 0.0, "R9", 1'b1);
    run_job(2'd2, 1'b0, 0.5, 0.2, -0.4,
            kh * (0.5 * $cosh(-0.4) + 0.2 * $sinh(-0.4)),
            kh * (0.2 * $cosh(-0.4) + 0.5 * $sinh(-0.4)), 0.0, "R9", 1'b0);
    // R10 hyperbolic vectoring
    run_job(2'd2, 1'b1, 1.0, 0.5, 0.0,
            kh * $sqrt(0.75), 0.0, $atanh(0.5), "R10", 1'b0);

    repeat (2) @(negedge clk);
    chk_int("R3", "scoreboard drained", sb.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule